// File: doc/BRIEF.md
# Packed Pixel Format Expander

This block takes one framebuffer pixel word per cycle, together with a 3-bit format code, and turns it into four 8-bit channels (alpha, red, green, blue) for the display path. Direct-colour formats are unpacked from fixed bit fields and the narrow channels are widened to 8 bits. The 8-bit indexed format looks its pixel up in an internal colour map. A host fills the map through a one-cycle write port. Every map word has the same byte layout as a 32-bit direct pixel, so both paths produce the same output word.

A pixel presented with `pix_valid` in one cycle appears on the outputs, with `out_valid`, after the next clock edge. The outputs hold their value while no pixel is presented. Format codes 3, 6 and 7 are not legal. A pixel carrying one of them comes out as transparent black, and a small controller moves from state `ST_CLEAN` to state `ST_FAULT`. That transition happens on a valid pixel with an illegal code, and it is the only transition the controller has. `ST_FAULT` drives `fmt_err` and is left only through reset. The colour map is not cleared by reset.

Top module: `pix_expand`

## Requirements
- R1: While reset is asserted and after reset is released, `out_valid` and `fmt_err` are 0 and all four output channels are 0 until a pixel is accepted.
- R2: `out_valid` equals `pix_valid` from the previous cycle. In a cycle that follows one without `pix_valid`, the channel outputs keep their previous values.
- R3: Format code 0 (indexed) uses `pix_word[7:0]` as an index into colour-map entries 0 to 255, and ignores bits 31:8. The outputs are the entry's bits 31:24 as alpha, 23:16 as red, 15:8 as green and 7:0 as blue.
- R4: Format code 1 (5-6-5) takes red from bits 15:11, green from 10:5 and blue from 4:0. It ignores bits 31:16 and gives alpha 0xFF.
- R5: Format code 2 (1-5-5-5) takes red from bits 14:10, green from 9:5 and blue from 4:0. Alpha is 0xFF when bit 15 is 1 and 0x00 when it is 0.
- R6: Format code 4 (24-bit) takes red from bits 23:16, green from 15:8 and blue from 7:0. It ignores bits 31:24 and gives alpha 0xFF.
- R7: Format code 5 (32-bit) works like code 4, except that alpha is taken from bits 31:24.
- R8: A valid pixel with format code 3, 6 or 7 gives all four channels 0. It also sets `fmt_err`, which stays at 1 through later legal pixels until reset.
- R9: A 5-bit channel v widens to {v, v[4:2]} and a 6-bit channel v widens to {v, v[5:4]}.
- R10: A write with `cm_we` high and `cm_addr` below 1024 stores `cm_data` at that entry. The write is seen by pixels presented in the following cycle or later. A pixel presented in the same cycle as the write reads the old entry.
- R11: A write with `cm_addr` of 1024 or more leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_fmt | input | 3 | Format code of the pixel |
| pix_word | input | 32 | Packed pixel word |
| cm_we | input | 1 | Colour-map write strobe |
| cm_addr | input | 11 | Colour-map write index |
| cm_data | input | 32 | Colour-map entry {alpha, red, green, blue} |
| out_valid | output | 1 | Expanded pixel present |
| out_a | output | 8 | Alpha channel |
| out_r | output | 8 | Red channel |
| out_g | output | 8 | Green channel |
| out_b | output | 8 | Blue channel |
| fmt_err | output | 1 | Sticky illegal-format flag |

## Verification
Mid-scale channel values such as 10000b check the widening rule. A design that padded with zeros or ones would give 0x80 or 0x87 instead of 0x84, and one with a shifted field boundary between the 5-6-5 and 1-5-5-5 layouts would mix green and red bits.

The write-rejection case uses index 1029 and checks entry 5. A design that truncated the index instead of rejecting it would overwrite entry 5. A write to entry 1023 checks that index truncation does not alias it onto entry 255.

A write and a read to the same entry in the same cycle check that the read sees the old contents. A legal pixel sent after an illegal one checks that the error flag stays set, and a later reset checks that it clears. Idle cycles check that the outputs hold rather than recompute from whatever sits on the pixel inputs.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

    typedef enum logic [2:0] {
        FMT_IDX8     = 3'd0,
        FMT_RGB565   = 3'd1,
        FMT_ARGB1555 = 3'd2,
        FMT_RSV3     = 3'd3,
        FMT_RGB888   = 3'd4,
        FMT_ARGB8888 = 3'd5,
        FMT_RSV6     = 3'd6,
        FMT_RSV7     = 3'd7
    } pix_fmt_e;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgba_t;

    // widen a 5-bit channel by repeating its top bits
    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    // widen a 6-bit channel by repeating its top bits
    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    function automatic logic fmt_legal(input pix_fmt_e f);
        return (f == FMT_IDX8) || (f == FMT_RGB565) || (f == FMT_ARGB1555) ||
               (f == FMT_RGB888) || (f == FMT_ARGB8888);
    endfunction

endpackage

// File: rtl/pxe_cmap.sv
module pxe_cmap #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32,
    parameter int RD_W   = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [RD_W-1:0]   rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              in_range;

    assign in_range = ({1'b0, wr_addr} < LIMIT);

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    assign rd_data = mem[IDX_W'(rd_idx)];

endmodule

// File: rtl/pxe_direct.sv
module pxe_direct
    import pxe_pkg::*;
(
    input  pix_fmt_e    fmt,
    input  logic [31:0] word,
    output rgba_t       px
);
    always_comb begin
        px = '0;
        unique case (fmt)
            FMT_RGB565: begin
                px.a = 8'hFF;
                px.r = widen5(word[15:11]);
                px.g = widen6(word[10:5]);
                px.b = widen5(word[4:0]);
            end
            FMT_ARGB1555: begin
                px.a = {8{word[15]}};
                px.r = widen5(word[14:10]);
                px.g = widen5(word[9:5]);
                px.b = widen5(word[4:0]);
            end
            FMT_RGB888: begin
                px.a = 8'hFF;
                px.r = word[23:16];
                px.g = word[15:8];
                px.b = word[7:0];
            end
            FMT_ARGB8888: begin
                px = word;
            end
            FMT_IDX8, FMT_RSV3, FMT_RSV6, FMT_RSV7: begin
                px = '0;
            end
        endcase
    end
endmodule

// File: rtl/pxe_ctrl.sv
module pxe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_valid,
    input  logic legal,
    output logic fmt_err
);
    typedef enum logic {ST_CLEAN = 1'b0, ST_FAULT = 1'b1} ctrl_st_e;

    ctrl_st_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAN: if (pix_valid && !legal) state_nx = ST_FAULT;
            ST_FAULT: state_nx = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_CLEAN: fmt_err = 1'b0;
            ST_FAULT: fmt_err = 1'b1;
        endcase
    end

    // R8: flag is sticky until reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);
    // R8: an illegal pixel always raises the flag
    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !legal) |=> fmt_err);

endmodule

// File: rtl/pix_expand.sv
module pix_expand
    import pxe_pkg::*;
#(
    parameter int CMAP_DEPTH = 1024,
    parameter int CM_ADDR_W  = 11,
    parameter int PIX_W      = 32,
    parameter int IDX_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_valid,
    input  logic [2:0]           pix_fmt,
    input  logic [PIX_W-1:0]     pix_word,
    input  logic                 cm_we,
    input  logic [CM_ADDR_W-1:0] cm_addr,
    input  logic [PIX_W-1:0]     cm_data,
    output logic                 out_valid,
    output logic [7:0]           out_a,
    output logic [7:0]           out_r,
    output logic [7:0]           out_g,
    output logic [7:0]           out_b,
    output logic                 fmt_err
);
    pix_fmt_e          fmt;
    rgba_t             direct_px, sel_px, px_q;
    logic [PIX_W-1:0]  cm_rd;
    logic              legal;

    assign fmt   = pix_fmt_e'(pix_fmt);
    assign legal = fmt_legal(fmt);

    pxe_cmap #(
        .DEPTH (CMAP_DEPTH),
        .ADDR_W(CM_ADDR_W),
        .DATA_W(PIX_W),
        .RD_W  (IDX_W)
    ) u_cmap (
        .clk    (clk),
        .we     (cm_we),
        .wr_addr(cm_addr),
        .wr_data(cm_data),
        .rd_idx (pix_word[IDX_W-1:0]),
        .rd_data(cm_rd)
    );

    pxe_direct u_direct (
        .fmt (fmt),
        .word(pix_word),
        .px  (direct_px)
    );

    pxe_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_valid(pix_valid),
        .legal    (legal),
        .fmt_err  (fmt_err)
    );

    always_comb begin
        if (fmt == FMT_IDX8) sel_px = cm_rd;
        else if (legal)      sel_px = direct_px;
        else                 sel_px = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            px_q      <= '0;
        end else begin
            out_valid <= pix_valid;
            if (pix_valid) px_q <= sel_px;
        end
    end

    assign out_a = px_q.a;
    assign out_r = px_q.r;
    assign out_g = px_q.g;
    assign out_b = px_q.b;

    // R2: output valid follows input valid by one cycle
    a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!out_valid && $stable(out_a) && $stable(out_r) &&
                        $stable(out_g) && $stable(out_b)));
    // R7: 32-bit alpha passes through
    a_r7_alpha: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_fmt == 3'd5) |=> (out_a == $past(pix_word[31:24])));
    // R5: single alpha bit expands to fully on or off
    a_r5_alpha: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_fmt == 3'd2) |=> (out_a == 8'h00 || out_a == 8'hFF));
    // R8: illegal code gives transparent black
    a_r8_black: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (pix_fmt == 3'd3 || pix_fmt == 3'd6 || pix_fmt == 3'd7))
        |=> ({out_a, out_r, out_g, out_b} == 32'h0));

endmodule

// File: tb/pix_expand_bench.sv
`timescale 1ns/1ps
module pix_expand_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [2:0]  pix_fmt = 3'd0;
    logic [31:0] pix_word = 32'h0;
    logic        cm_we = 1'b0;
    logic [10:0] cm_addr = 11'h0;
    logic [31:0] cm_data = 32'h0;
    logic        out_valid, fmt_err;
    logic [7:0]  out_a, out_r, out_g, out_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pix_expand u_pix_expand (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_fmt(pix_fmt),
        .pix_word(pix_word), .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data),
        .out_valid(out_valid), .out_a(out_a), .out_r(out_r), .out_g(out_g),
        .out_b(out_b), .fmt_err(fmt_err)
    );

    // {format, pixel word, expected {a,r,g,b}}
    localparam int NVEC = 11;
    localparam logic [66:0] VEC [NVEC] = '{
        {3'd1, 32'h0000F800, 32'hFFFF0000},
        {3'd1, 32'h000007E0, 32'hFF00FF00},
        {3'd1, 32'h0000001F, 32'hFF0000FF},
        {3'd1, 32'h00008410, 32'hFF848284},
        {3'd1, 32'hABCD0000, 32'hFF000000},
        {3'd2, 32'h00008000, 32'hFF000000},
        {3'd2, 32'h00007FFF, 32'h00FFFFFF},
        {3'd2, 32'h00004210, 32'h00848484},
        {3'd4, 32'hAA123456, 32'hFF123456},
        {3'd5, 32'hAA123456, 32'hAA123456},
        {3'd5, 32'h00FFFFFF, 32'h00FFFFFF}
    };

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'd1:    return "R4/R9";
            3'd2:    return "R5/R9";
            3'd4:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] f, input logic [31:0] w);
        @(negedge clk);
        pix_valid = 1'b1; pix_fmt = f; pix_word = w;
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic cm_write(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        cm_we = 1'b1; cm_addr = a; cm_data = d;
        @(negedge clk);
        cm_we = 1'b0;
    endtask

    function automatic logic [31:0] outw();
        return {out_a, out_r, out_g, out_b};
    endfunction

    initial begin
        #1;
        check("R1 reset valid", {31'h0, out_valid}, 32'h0);
        repeat (3) @(negedge clk);
        check("R1 reset err", {31'h0, fmt_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset outputs", outw(), 32'h0);
        check("R1 after reset valid", {31'h0, out_valid}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][66:64], VEC[i][63:32]);
            check(tag_of(VEC[i][66:64]), outw(), VEC[i][31:0]);
            check("R2 valid", {31'h0, out_valid}, 32'h1);
        end

        // R2: hold while idle, even with changing inputs
        pix_word = 32'h11111111; pix_fmt = 3'd5;
        @(negedge clk);
        check("R2 idle valid", {31'h0, out_valid}, 32'h0);
        check("R2 hold data", outw(), 32'h00FFFFFF);

        // R3 / R10: colour map path
        cm_write(11'd5, 32'h80112233);
        send(3'd0, 32'hFFFFFF05);
        check("R3 indexed", outw(), 32'h80112233);
        cm_write(11'd255, 32'h01020304);
        cm_write(11'd1023, 32'hDEADBEEF);
        send(3'd0, 32'h000000FF);
        check("R10 entry 255 not aliased", outw(), 32'h01020304);

        // R11: out-of-range index rejected
        cm_write(11'd1029, 32'h55555555);
        send(3'd0, 32'h00000005);
        check("R11 rejected write", outw(), 32'h80112233);

        // R10: same-cycle write and read sees old entry, next sees new
        @(negedge clk);
        cm_we = 1'b1; cm_addr = 11'd5; cm_data = 32'hCAFEF00D;
        pix_valid = 1'b1; pix_fmt = 3'd0; pix_word = 32'h5;
        @(negedge clk);
        cm_we = 1'b0;
        check("R10 same cycle old", outw(), 32'h80112233);
        @(negedge clk);
        pix_valid = 1'b0;
        check("R10 next cycle new", outw(), 32'hCAFEF00D);

        // R8: illegal format codes
        check("R8 no err yet", {31'h0, fmt_err}, 32'h0);
        send(3'd3, 32'hFFFFFFFF);
        check("R8 black code3", outw(), 32'h0);
        check("R8 flag set", {31'h0, fmt_err}, 32'h1);
        send(3'd4, 32'h00ABCDEF);
        check("R8 legal after", outw(), 32'hFFABCDEF);
        check("R8 sticky", {31'h0, fmt_err}, 32'h1);
        send(3'd7, 32'h12345678);
        check("R8 black code7", outw(), 32'h0);
        send(3'd6, 32'h12345678);
        check("R8 black code6", outw(), 32'h0);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1/R8 reset clears flag", {31'h0, fmt_err}, 32'h0);
        check("R1 reset clears data", outw(), 32'h0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule